// File: doc/BRIEF.md
# BitBlt Line Sequencer

This block steers a raster-operation datapath while a CPU runs a hardware block-transfer instruction. Software first loads a byte-wide width register with the two's complement of the line width, counted in 16-bit words. It then loads a byte-wide control register that holds the mask enables, a pre-read flag and an enable bit. Writing the control register also loads the working word counter from the width register and starts a new line. Software must therefore write the width register first.

While the block-transfer signal is high, the sequencer watches completed bus cycles whose status code marks a data transfer. Each word of a line is one group of cycles: an optional source pre-read on the first word only, then a source read, a destination read and a destination write. From these cycles the sequencer produces a source/destination phase flag and one-cycle latch strobes for the datapath. It also produces left and right mask enables, which it chooses for the first, middle and last word of each line. The working counter counts up to its terminal value to find the last word, and it reloads itself at the end of every line.

The state machine has five states. `ST_OFF` means disabled. `ST_PRE` expects a source pre-read, `ST_SRC` a source read, `ST_DRD` a destination read and `ST_DWR` a destination write. The transitions are:
- A control write with enable set moves the machine to `ST_PRE` if pre-read is set, otherwise to `ST_SRC`.
- A control write with enable clear moves it to `ST_OFF`.
- `ST_PRE` goes to `ST_SRC` on a read.
- `ST_SRC` goes to `ST_DRD` on a read.
- `ST_DRD` goes to `ST_DWR` on a read.
- `ST_DWR` goes on a write to `ST_SRC` for a word that is not the last. On the last word it goes to `ST_PRE` or `ST_SRC`, depending on the pre-read flag, for the next line.
- Any state falls to `ST_OFF` while the stored enable bit is clear.

Top module: `blt_line_seq`

## Requirements
- R1: Reset clears both registers. A write with address 3 loads the width register and a write with address 2 loads the control register. Writes to any other address change nothing.
- R2: The working counter is loaded from the width register only when the control register is written, and again at each line end. A width-register write during a line leaves the current line's length unchanged and sets the length of the following lines.
- R3: A width value V gives lines of 256−V words, so 0xFF gives 1 word and 0x00 gives 256 words. The counter advances only on an accepted destination write of a word that is not the last one.
- R4: The word in which the counter holds 0xFF is the last word of the line. After its destination write, the next group is the first word of a new line.
- R5: When control bit 2 (pre-read) is set, the first word of every line needs two source reads before its destination read. Other words need one.
- R6: `src_phase` is high while a source pre-read or source read is expected, and low while a destination read or destination write is expected or while the block is off.
- R7: One cycle after an accepted cycle completes, exactly one strobe pulses for one cycle. `src_latch` pulses for a source (pre-)read, `dst_latch` for a destination read and `dst_write` for a destination write.
- R8: While control bit 3 (enable) is clear, `dp_reset` is high, `src_phase` and both masks are low, and no strobe is produced.
- R9: Control bits 7, 6, 5 and 4 are begin-right, begin-left, end-right and end-left. On the first word, `mask_right` and `mask_left` follow bits 7 and 6. On the last word they follow bits 5 and 4. On middle words both are low. A one-word line uses bits 7 and 6.
- R10: A bus cycle is accepted only when `blt_active` is high and `bus_status` equals 3'b101. Any other cycle is ignored.
- R11: A cycle whose direction does not match the expected step is ignored. Such a cycle is a write while a read is expected, or a read while a write is expected.
- R12: While `blt_active` is low between groups, the word position, line state and masks hold. The line then continues when the signal returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (3 = width, 2 = control) |
| reg_wdata | input | 8 | Register write data |
| blt_active | input | 1 | Block-transfer instruction in progress |
| bus_status | input | 3 | Bus cycle status code |
| bus_done | input | 1 | One-cycle pulse at completion of a bus cycle |
| bus_write | input | 1 | Direction of the completing cycle (1 = write) |
| src_phase | output | 1 | High while a source read is expected |
| src_latch | output | 1 | Source data latch strobe |
| dst_latch | output | 1 | Destination data latch strobe |
| dst_write | output | 1 | Destination write completed strobe |
| mask_left | output | 1 | Left mask enable for the current word |
| mask_right | output | 1 | Right mask enable for the current word |
| dp_reset | output | 1 | Datapath reset (block disabled) |

## Verification
A wrong state shows on `src_phase` before the next cycle. It also shows in the strobe that follows the next accepted cycle, exactly one clock after its completion, because that strobe names the wrong kind of access. A wrong word counter stays hidden until the mask outputs reach the end of the line. It then shows as end masks on the wrong word, or as a missing first-word pre-read on the following line. The bench therefore checks masks and phase before every step of every word, across lines of 1, 2, 3 and 256 words.

// File: rtl/blt_seq_pkg.sv
package blt_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF = 3'd0,
        ST_PRE = 3'd1,
        ST_SRC = 3'd2,
        ST_DRD = 3'd3,
        ST_DWR = 3'd4
    } seq_state_t;

    // control register bit positions
    localparam int CB_BEG_R = 7;
    localparam int CB_BEG_L = 6;
    localparam int CB_END_R = 5;
    localparam int CB_END_L = 4;
    localparam int CB_EN    = 3;
    localparam int CB_PRE   = 2;

    typedef struct packed {
        logic beg_r;
        logic beg_l;
        logic end_r;
        logic end_l;
        logic enable;
        logic preread;
    } ctl_cfg_t;

    function automatic ctl_cfg_t decode_ctl(input logic [7:0] d);
        ctl_cfg_t c;
        c.beg_r   = d[CB_BEG_R];
        c.beg_l   = d[CB_BEG_L];
        c.end_r   = d[CB_END_R];
        c.end_l   = d[CB_END_L];
        c.enable  = d[CB_EN];
        c.preread = d[CB_PRE];
        return c;
    endfunction

endpackage

// File: rtl/blt_regs.sv
module blt_regs
    import blt_seq_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int CNT_ADDR  = 3,
    parameter int CTL_ADDR  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] width_val,
    output ctl_cfg_t          cfg,
    output logic              ctl_wr,
    output ctl_cfg_t          new_cfg
);

    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CNT_ADDR);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);

    logic     cnt_wr;
    ctl_cfg_t cfg_q;
    logic [DATA_W-1:0] width_q;

    assign cnt_wr  = reg_wr && (reg_addr == A_CNT);
    assign ctl_wr  = reg_wr && (reg_addr == A_CTL);
    assign new_cfg = decode_ctl(reg_wdata[7:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
            cfg_q   <= '0;
        end else begin
            if (cnt_wr) width_q <= reg_wdata;
            if (ctl_wr) cfg_q   <= new_cfg;
        end
    end

    assign width_val = width_q;
    assign cfg       = cfg_q;

    // R1: writes to unmapped addresses leave both registers untouched
    assert_ignore_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != A_CNT && reg_addr != A_CTL) |=> ($stable(width_q) && $stable(cfg_q)));

endmodule

// File: rtl/blt_word_counter.sv
module blt_word_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             adv,
    output logic             count_last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (adv)  cnt_q <= cnt_q + 1'b1;
    end

    assign count_last = &cnt_q;

    // R3: the count only moves when told to
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(cnt_q));

    // R2: a load takes the presented width value
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/blt_seq_fsm.sv
module blt_seq_fsm
    import blt_seq_pkg::*;
#(
    parameter int          STAT_W      = 3,
    parameter int          DATA_STATUS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  ctl_cfg_t          start_cfg,
    input  ctl_cfg_t          cfg,
    input  logic              blt_active,
    input  logic [STAT_W-1:0] bus_status,
    input  logic              bus_done,
    input  logic              bus_write,
    input  logic              count_last,
    output logic              src_phase,
    output logic              src_latch,
    output logic              dst_latch,
    output logic              dst_write,
    output logic              mask_left,
    output logic              mask_right,
    output logic              cnt_adv,
    output logic              cnt_reload
);

    localparam logic [STAT_W-1:0] ST_CODE = STAT_W'(DATA_STATUS);
    localparam int SIDES = 2; // index 0 = left, 1 = right

    seq_state_t state_q, state_d;
    logic first_q, first_d;
    logic take_src, take_drd, take_wr;
    logic src_latch_q, dst_latch_q, dst_write_q;
    logic qual;

    assign qual = bus_done && blt_active && (bus_status == ST_CODE);

    // next state
    always_comb begin
        state_d    = state_q;
        first_d    = first_q;
        take_src   = 1'b0;
        take_drd   = 1'b0;
        take_wr    = 1'b0;
        cnt_adv    = 1'b0;
        cnt_reload = 1'b0;
        if (line_start) begin
            first_d = 1'b1;
            if (start_cfg.enable) state_d = start_cfg.preread ? ST_PRE : ST_SRC;
            else                  state_d = ST_OFF;
        end else if (!cfg.enable) begin
            state_d = ST_OFF;
        end else if (qual) begin
            unique case (state_q)
                ST_OFF: state_d = ST_OFF;
                ST_PRE: if (!bus_write) begin
                    state_d  = ST_SRC;
                    take_src = 1'b1;
                end
                ST_SRC: if (!bus_write) begin
                    state_d  = ST_DRD;
                    take_src = 1'b1;
                end
                ST_DRD: if (!bus_write) begin
                    state_d  = ST_DWR;
                    take_drd = 1'b1;
                end
                ST_DWR: if (bus_write) begin
                    take_wr = 1'b1;
                    if (count_last) begin
                        cnt_reload = 1'b1;
                        first_d    = 1'b1;
                        state_d    = cfg.preread ? ST_PRE : ST_SRC;
                    end else begin
                        cnt_adv = 1'b1;
                        first_d = 1'b0;
                        state_d = ST_SRC;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_OFF;
            first_q     <= 1'b0;
            src_latch_q <= 1'b0;
            dst_latch_q <= 1'b0;
            dst_write_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            first_q     <= first_d;
            src_latch_q <= take_src;
            dst_latch_q <= take_drd;
            dst_write_q <= take_wr;
        end
    end

    // outputs
    logic [SIDES-1:0] beg_bits, end_bits, mask_vec;
    logic             running;

    always_comb begin
        running   = (state_q != ST_OFF);
        src_phase = (state_q == ST_PRE) || (state_q == ST_SRC);
        beg_bits  = {cfg.beg_r, cfg.beg_l};
        end_bits  = {cfg.end_r, cfg.end_l};
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        assign mask_vec[s] = running && (first_q ? beg_bits[s]
                                                 : (count_last && end_bits[s]));
    end

    assign mask_left  = mask_vec[0];
    assign mask_right = mask_vec[1];
    assign src_latch  = src_latch_q;
    assign dst_latch  = dst_latch_q;
    assign dst_write  = dst_write_q;

    // R7: never more than one strobe at once
    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_latch_q, dst_latch_q, dst_write_q}));

    // R6: a source strobe follows a cycle spent in source phase
    assert_src_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        src_latch_q |-> $past(src_phase));

    // R4: line-end reload only on the terminal count
    assert_reload_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_reload |-> count_last);

    // R3: advance only on a write that is not the last word
    assert_adv_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_adv |-> (bus_write && !count_last));

endmodule

// File: rtl/blt_line_seq.sv
module blt_line_seq
    import blt_seq_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int CNT_ADDR    = 3,
    parameter int CTL_ADDR    = 2,
    parameter int STAT_W      = 3,
    parameter int DATA_STATUS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              blt_active,
    input  logic [STAT_W-1:0] bus_status,
    input  logic              bus_done,
    input  logic              bus_write,
    output logic              src_phase,
    output logic              src_latch,
    output logic              dst_latch,
    output logic              dst_write,
    output logic              mask_left,
    output logic              mask_right,
    output logic              dp_reset
);

    localparam int CNT_W = DATA_W;

    logic [CNT_W-1:0] width_val;
    ctl_cfg_t         cfg, new_cfg;
    logic             ctl_wr, cnt_adv, cnt_reload, count_last;

    blt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_ADDR(CNT_ADDR), .CTL_ADDR(CTL_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .width_val(width_val), .cfg(cfg),
        .ctl_wr(ctl_wr), .new_cfg(new_cfg)
    );

    blt_word_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(ctl_wr || cnt_reload),
        .load_val(width_val), .adv(cnt_adv), .count_last(count_last)
    );

    blt_seq_fsm #(.STAT_W(STAT_W), .DATA_STATUS(DATA_STATUS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_start(ctl_wr), .start_cfg(new_cfg),
        .cfg(cfg), .blt_active(blt_active), .bus_status(bus_status),
        .bus_done(bus_done), .bus_write(bus_write), .count_last(count_last),
        .src_phase(src_phase), .src_latch(src_latch), .dst_latch(dst_latch),
        .dst_write(dst_write), .mask_left(mask_left), .mask_right(mask_right),
        .cnt_adv(cnt_adv), .cnt_reload(cnt_reload)
    );

    assign dp_reset = !cfg.enable;

    // R8: a disabled block stays silent
    assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dp_reset |=> !(src_latch || dst_latch || dst_write));

    // R8: masks and phase low while disabled
    assert_off_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_reset && $past(dp_reset)) |-> !(src_phase || mask_left || mask_right));

endmodule

// File: tb/test_blt_line_seq.sv
module test_blt_line_seq;

    localparam logic [1:0] A_CNT = 2'd3;
    localparam logic [1:0] A_CTL = 2'd2;
    localparam logic [2:0] DST   = 3'b101;
    localparam int K_SRC = 1, K_DRD = 2, K_WR = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, reg_wr, blt_active, bus_done, bus_write;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [2:0] bus_status;
    logic src_phase, src_latch, dst_latch, dst_write, mask_left, mask_right, dp_reset;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    bit finished = 0;

    blt_line_seq i_blt_line_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .blt_active(blt_active), .bus_status(bus_status),
        .bus_done(bus_done), .bus_write(bus_write), .src_phase(src_phase),
        .src_latch(src_latch), .dst_latch(dst_latch), .dst_write(dst_write),
        .mask_left(mask_left), .mask_right(mask_right), .dp_reset(dp_reset)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected strobe kinds (R7)
    always @(negedge clk) begin : mon
        int act;
        int e;
        if (rst_n && (src_latch || dst_latch || dst_write)) begin
            act = src_latch ? K_SRC : (dst_latch ? K_DRD : K_WR);
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7 strobe actual %0d expected none", act);
            end else begin
                e = exp_q.pop_front();
                if (e != act) begin
                    fails++;
                    $display("FAIL R7 strobe actual %0d expected %0d", act, e);
                end
            end
        end
    end

    task automatic reg_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus(logic wr, logic [2:0] st, logic act);
        @(negedge clk);
        bus_done = 1'b1; bus_write = wr; bus_status = st; blt_active = act;
        @(negedge clk);
        bus_done = 1'b0; blt_active = 1'b1;
    endtask

    task automatic group(bit pre, bit el, bit er, string tag);
        chk({tag, " R6 phase at group start"}, src_phase, 1);
        chk({tag, " R9 mask_left"}, mask_left, el);
        chk({tag, " R9 mask_right"}, mask_right, er);
        if (pre) begin
            exp_q.push_back(K_SRC);
            bus(1'b0, DST, 1'b1);
            chk({tag, " R5 phase after pre-read"}, src_phase, 1);
        end
        exp_q.push_back(K_SRC);
        bus(1'b0, DST, 1'b1);
        chk({tag, " R6 phase at dest read"}, src_phase, 0);
        chk({tag, " R9 mask_left held"}, mask_left, el);
        chk({tag, " R9 mask_right held"}, mask_right, er);
        exp_q.push_back(K_DRD);
        bus(1'b0, DST, 1'b1);
        chk({tag, " R6 phase at dest write"}, src_phase, 0);
        exp_q.push_back(K_WR);
        bus(1'b1, DST, 1'b1);
    endtask

    function automatic bit msel(logic [7:0] m, bit right, bit first, bit last);
        if (first) return right ? m[7] : m[6];
        if (last)  return right ? m[5] : m[4];
        return 1'b0;
    endfunction

    task automatic line(logic [7:0] m, int width, string tag);
        for (int w = 0; w < width; w++) begin
            bit f, l;
            f = (w == 0);
            l = (w == width - 1);
            group(f && m[2], msel(m, 0, f, l), msel(m, 1, f, l), tag);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        blt_active = 1'b0; bus_done = 1'b0; bus_write = 1'b0; bus_status = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset dp_reset", dp_reset, 1);
        chk("R8 reset phase", src_phase, 0);
        chk("R8 reset masks", {mask_left, mask_right}, 0);

        // width 2, begin right + end left
        reg_write(A_CNT, 8'hFE);
        chk("R2 count write alone keeps block off", dp_reset, 1);
        reg_write(A_CTL, 8'h98);
        chk("R1 control write enables", dp_reset, 0);
        line(8'h98, 2, "R3 R4 w2 line1");
        line(8'h98, 2, "R4 w2 line2");

        // width 3: middle word unmasked
        reg_write(A_CNT, 8'hFD);
        reg_write(A_CTL, 8'h98);
        line(8'h98, 3, "R9 w3");

        // width 1 uses beginning pair
        reg_write(A_CNT, 8'hFF);
        reg_write(A_CTL, 8'h68);
        line(8'h68, 1, "R9 w1 line1");
        line(8'h68, 1, "R3 w1 line2");

        // pre-read on every line start
        reg_write(A_CNT, 8'hFE);
        reg_write(A_CTL, 8'hFC);
        line(8'hFC, 2, "R5 pre line1");
        line(8'hFC, 2, "R5 pre line2");

        // qualification and wrong direction
        reg_write(A_CTL, 8'h98);
        bus(1'b0, 3'b000, 1'b1);
        bus(1'b0, DST, 1'b0);
        chk("R10 unqualified ignored", src_phase, 1);
        bus(1'b1, DST, 1'b1);
        chk("R11 write in source step ignored", src_phase, 1);
        line(8'h98, 2, "R10 R11 line intact");

        // interruption between groups
        group(0, 1'b0, 1'b1, "R12 first word");
        bus(1'b0, DST, 1'b0);
        bus(1'b1, DST, 1'b0);
        chk("R12 masks held after pause", {mask_left, mask_right}, 2'b10);
        group(0, 1'b1, 1'b0, "R12 last word");
        line(8'h98, 2, "R12 next line");

        // width register written mid-line
        group(0, 1'b0, 1'b1, "R2 first word");
        reg_write(A_CNT, 8'hFD);
        group(0, 1'b1, 1'b0, "R2 old length ends");
        line(8'h98, 3, "R2 new length");

        // 256-word line
        reg_write(A_CNT, 8'h00);
        reg_write(A_CTL, 8'h98);
        line(8'h98, 256, "R3 w256");
        chk("R4 new line after 256", {mask_left, mask_right}, 2'b01);

        // disable
        reg_write(A_CTL, 8'h00);
        chk("R8 dp_reset", dp_reset, 1);
        chk("R8 phase off", src_phase, 0);
        chk("R8 masks off", {mask_left, mask_right}, 0);
        bus(1'b0, DST, 1'b1);
        bus(1'b1, DST, 1'b1);

        // unmapped addresses
        reg_write(2'd0, 8'hFF);
        reg_write(2'd1, 8'hFF);
        chk("R1 unmapped write keeps off", dp_reset, 1);
        reg_write(A_CTL, 8'h98);
        line(8'h98, 256, "R1 width kept after unmapped");

        repeat (3) @(negedge clk);
        chk("R7 no pending strobes", exp_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule